// File: doc/BRIEF.md
# Iterative Odd-Even Transposition Sorter

This block orders a set of N unsigned samples taken in one cycle from a bank of window registers. It is meant for detection datapaths where the sort clock is several times faster than the rate at which new windows arrive. A single data strobe captures all N samples at once. One shared row of compare-exchange cells is then reused on every following cycle until the list is in ascending order.

Each step runs one even row of N/2 cells and one odd row of N/2-1 cells. By default both rows sit in one combinational path, so a sort takes N/2 steps. A build parameter can insert a register between the rows. The rows then take turns on alternate cycles, which shortens the critical path and raises the worst case to N steps.

The finish flag normally rises after the fixed worst-case count. A run-time early-finish input lets it rise as soon as one full even and odd pass exchanges nothing. The whole ordered vector is presented, together with one element picked by rank.

Top module: `oet_sorter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done_o` and `overrun_o` are 0 and `sorted_o` is all zero.
- R2: A strobe sampled while the block is idle captures all N lanes of `win_data` at that clock edge, and `done_o` is 0 after that edge.
- R3: When `done_o` is 1, `sorted_o` holds the captured samples in ascending order, with repeated values kept. The smallest value is in lane 0, at bits [W-1:0], and lane i is at bits [i*W +: W].
- R4: With PIPE=0 and the early-finish input low, `done_o` rises exactly N/2 clock edges after the capturing edge.
- R5: With PIPE=1 and the early-finish input low, `done_o` rises exactly N clock edges after the capturing edge.
- R6: With the early-finish input high, `done_o` rises after the first full even and odd pass that exchanges nothing, and never later than the fixed count. For input that is already in order, this is 1 edge after the capture for PIPE=0 and 2 edges for PIPE=1.
- R7: Once `done_o` is 1, it and `sorted_o` hold their values until the next accepted strobe, whatever `win_data` does.
- R8: A strobe sampled while a sort is still running is ignored: the result is that of the earlier capture. `overrun_o` is 1 for exactly the one cycle after that edge, and it is 0 otherwise.
- R9: `rank_o` equals lane `rank_sel` of `sorted_o`, where rank 0 is the smallest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sort clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Data strobe; captures a new window when idle |
| win_data | input | N*W | N window samples, lane i at bits [i*W +: W] |
| early_en | input | 1 | 1 = finish on the first pass with no exchange |
| rank_sel | input | $clog2(N) | Rank to present on rank_o |
| sorted_o | output | N*W | Ordered samples, ascending from lane 0 |
| rank_o | output | W | Sample at the selected rank |
| done_o | output | 1 | Sort complete; held until the next capture |
| overrun_o | output | 1 | One-cycle pulse: a strobe arrived while busy |

## Verification
The checker takes for granted that `early_en` is held steady from a capture until the matching `done_o`. It also relies on `win_data` being looked at only on an accepted strobe, so its value at other times is irrelevant to the properties. The stimulus respects both points. It changes `early_en` only between sorts, and it moves `win_data` while idle only in the hold test that is meant to show it has no effect. Strobes are single-cycle pulses, except for the one deliberate second pulse that provokes an overrun during a running sort.

// File: rtl/oet_pkg.sv
package oet_pkg;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_SORT = 1'b1
  } ctl_state_e;

  // Worst-case number of sort steps after the capture edge
  function automatic int sort_steps(input int n, input int pipe);
    return (pipe != 0) ? n : n / 2;
  endfunction

endpackage

// File: rtl/oet_cmp_swap.sv
module oet_cmp_swap #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         swapped
);
  always_comb begin
    swapped = (a > b);
    lo      = swapped ? b : a;
    hi      = swapped ? a : b;
  end
endmodule

// File: rtl/oet_stage.sv
// One row of compare-exchange cells; ODD=0 pairs lanes (0,1),(2,3)...,
// ODD=1 pairs (1,2),(3,4)... and passes the end lanes straight through.
module oet_stage #(
  parameter int N   = 16,
  parameter int W   = 16,
  parameter bit ODD = 1'b0
) (
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout,
  output logic           any_swap
);
  localparam int BASE  = ODD ? 1 : 0;
  localparam int PAIRS = (N - BASE) / 2;

  logic [PAIRS-1:0] sw;

  for (genvar p = 0; p < PAIRS; p++) begin : g_cse
    oet_cmp_swap #(.W(W)) u_cse (
      .a      (din [(BASE + 2*p)     * W +: W]),
      .b      (din [(BASE + 2*p + 1) * W +: W]),
      .lo     (dout[(BASE + 2*p)     * W +: W]),
      .hi     (dout[(BASE + 2*p + 1) * W +: W]),
      .swapped(sw[p])
    );
  end

  if (ODD) begin : g_ends
    assign dout[W-1:0]       = din[W-1:0];
    assign dout[N*W-1 -: W]  = din[N*W-1 -: W];
  end

  assign any_swap = |sw;
endmodule

// File: rtl/oet_ctrl.sv
module oet_ctrl
  import oet_pkg::*;
#(
  parameter int N    = 16,
  parameter int PIPE = 0,
  localparam int S   = sort_steps(N, PIPE),
  localparam int CW  = $clog2(S + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic early_en,
  input  logic swap_even,
  input  logic swap_odd,
  output logic load,
  output logic busy,
  output logic phase_odd,
  output logic done_o,
  output logic overrun_o
);
  ctl_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           phase_q;
  logic           even_clean_q;
  logic           done_q;
  logic           ovr_q;
  logic           early_hit;
  logic           finish;

  always_comb begin
    load = strobe && (state_q == CTL_IDLE);
    busy = (state_q == CTL_SORT);
    if (PIPE != 0)
      early_hit = early_en && phase_q && even_clean_q && !swap_odd;
    else
      early_hit = early_en && !swap_even && !swap_odd;
    finish = busy && ((cnt_q == CW'(S - 1)) || early_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= CTL_IDLE;
      cnt_q        <= '0;
      phase_q      <= 1'b0;
      even_clean_q <= 1'b0;
      done_q       <= 1'b0;
      ovr_q        <= 1'b0;
    end else begin
      ovr_q <= strobe && busy;
      if (load) begin
        state_q      <= CTL_SORT;
        cnt_q        <= '0;
        phase_q      <= 1'b0;
        even_clean_q <= 1'b0;
        done_q       <= 1'b0;
      end else if (busy) begin
        cnt_q        <= cnt_q + 1'b1;
        phase_q      <= ~phase_q;
        even_clean_q <= ~phase_q && !swap_even;
        if (finish) begin
          state_q <= CTL_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign phase_odd = phase_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/oet_rank_pick.sv
module oet_rank_pick #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int RW = 4
) (
  input  logic [N*W-1:0] vec,
  input  logic [RW-1:0]  sel,
  output logic [W-1:0]   val
);
  always_comb begin
    val = '0;
    for (int i = 0; i < N; i++)
      if (sel == RW'(i)) val = vec[i*W +: W];
  end
endmodule

// File: rtl/oet_sorter.sv
module oet_sorter #(
  parameter int N    = 16,
  parameter int W    = 16,
  parameter int PIPE = 0,
  localparam int RW  = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  logic [N*W-1:0] win_data,
  input  logic           early_en,
  input  logic [RW-1:0]  rank_sel,
  output logic [N*W-1:0] sorted_o,
  output logic [W-1:0]   rank_o,
  output logic           done_o,
  output logic           overrun_o
);
  logic [N*W-1:0] data_q;
  logic [N*W-1:0] data_d;
  logic [N*W-1:0] even_out;
  logic [N*W-1:0] odd_in;
  logic [N*W-1:0] odd_out;
  logic           swap_even;
  logic           swap_odd;
  logic           load;
  logic           busy;
  logic           phase_odd;

  oet_stage #(.N(N), .W(W), .ODD(1'b0)) u_even (
    .din(data_q), .dout(even_out), .any_swap(swap_even)
  );

  assign odd_in = (PIPE != 0) ? data_q : even_out;

  oet_stage #(.N(N), .W(W), .ODD(1'b1)) u_odd (
    .din(odd_in), .dout(odd_out), .any_swap(swap_odd)
  );

  oet_ctrl #(.N(N), .PIPE(PIPE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .early_en (early_en),
    .swap_even(swap_even),
    .swap_odd (swap_odd),
    .load     (load),
    .busy     (busy),
    .phase_odd(phase_odd),
    .done_o   (done_o),
    .overrun_o(overrun_o)
  );

  always_comb begin
    if (load)
      data_d = win_data;
    else if (busy)
      data_d = (PIPE != 0) ? (phase_odd ? odd_out : even_out) : odd_out;
    else
      data_d = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= data_d;
  end

  assign sorted_o = data_q;

  oet_rank_pick #(.N(N), .W(W), .RW(RW)) u_rank (
    .vec(data_q), .sel(rank_sel), .val(rank_o)
  );
endmodule

// File: rtl/oet_sorter_chk.sv
module oet_sorter_chk
  import oet_pkg::*;
#(
  parameter int N    = 16,
  parameter int W    = 16,
  parameter int PIPE = 0
) (
  input logic           clk,
  input logic           rst,
  input logic           strobe,
  input logic           busy,
  input logic           done_o,
  input logic           overrun_o,
  input logic [N*W-1:0] sorted_o
);
  localparam int S = sort_steps(N, PIPE);

  function automatic logic is_asc(input logic [N*W-1:0] v);
    for (int i = 1; i < N; i++)
      if (v[i*W +: W] < v[(i-1)*W +: W]) return 1'b0;
    return 1'b1;
  endfunction

  int steps_q;
  always_ff @(posedge clk) begin
    if (rst)                  steps_q <= 0;
    else if (strobe && !busy) steps_q <= 0;
    else if (busy)            steps_q <= steps_q + 1;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_o && !overrun_o));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && !busy) |=> !done_o);

  p_order_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> is_asc(sorted_o));

  p_latency_bound_r4: assert property (@(posedge clk) disable iff (rst)
    steps_q <= S);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !strobe) |=> (done_o && $stable(sorted_o)));

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe && busy) |=> overrun_o);

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    !(strobe && busy) |=> !overrun_o);
endmodule

bind oet_sorter oet_sorter_chk #(.N(N), .W(W), .PIPE(PIPE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .strobe   (strobe),
  .busy     (busy),
  .done_o   (done_o),
  .overrun_o(overrun_o),
  .sorted_o (sorted_o)
);

// File: tb/sim_oet_sorter.sv
`timescale 1ns/1ps
module sim_oet_sorter;
  localparam int N  = 4;
  localparam int W  = 3;
  localparam int NW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobe = 1'b0;
  logic [NW-1:0] win = '0;
  logic          early = 1'b0;
  logic [1:0]    rsel = '0;
  logic [NW-1:0] s0, s1;
  logic [W-1:0]  r0, r1;
  logic          d0, d1, o0, o1;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  oet_sorter #(.N(N), .W(W), .PIPE(0)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .win_data(win), .early_en(early),
    .rank_sel(rsel), .sorted_o(s0), .rank_o(r0), .done_o(d0), .overrun_o(o0));

  oet_sorter #(.N(N), .W(W), .PIPE(1)) u1 (
    .clk(clk), .rst(rst), .strobe(strobe), .win_data(win), .early_en(early),
    .rank_sel(rsel), .sorted_o(s1), .rank_o(r1), .done_o(d1), .overrun_o(o1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [NW-1:0] ref_sort(input logic [NW-1:0] v);
    int a [N];
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (a[j] > a[j+1]) begin
          int t = a[j]; a[j] = a[j+1]; a[j+1] = t;
        end
    r = '0;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  // Strobe one window; returns the negedge index (0 = just after capture)
  // at which each instance first shows done.
  task automatic run_one(input logic [NW-1:0] pat, output int t0, output int t1);
    @(negedge clk); win = pat; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    check("R2 done low after capture u0", 32'(d0), 0);
    check("R2 done low after capture u1", 32'(d1), 0);
    check("R8 no overrun on idle strobe", 32'({o0, o1}), 0);
    t0 = -1; t1 = -1;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (t0 < 0 && d0) t0 = j;
      if (t1 < 0 && d1) t1 = j;
      if (t0 >= 0 && t1 >= 0) break;
    end
  endtask

  initial begin
    int t0, t1;
    logic [NW-1:0] exp, held, pa, pb;
    repeat (3) @(negedge clk);
    check("R1 done after reset", 32'({d0, d1}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done/overrun first cycle", 32'({d0, d1, o0, o1}), 0);
    check("R1 sorted zero u0", 32'(s0), 0);
    check("R1 sorted zero u1", 32'(s1), 0);

    // Exhaustive sweep, fixed worst-case count
    early = 1'b0;
    for (int p = 0; p < (1 << NW); p++) begin
      run_one(NW'(p), t0, t1);
      exp = ref_sort(NW'(p));
      check("R4 fixed latency N/2", 32'(t0), N / 2);
      check("R5 fixed latency N", 32'(t1), N);
      check("R3 ascending u0", 32'(s0), 32'(exp));
      check("R3 ascending u1", 32'(s1), 32'(exp));
    end

    // Exhaustive sweep, early finish
    early = 1'b1;
    for (int p = 0; p < (1 << NW); p++) begin
      run_one(NW'(p), t0, t1);
      exp = ref_sort(NW'(p));
      check("R3 ascending early u0", 32'(s0), 32'(exp));
      check("R3 ascending early u1", 32'(s1), 32'(exp));
      if (exp == NW'(p)) begin
        check("R6 early in-order u0", 32'(t0), 1);
        check("R6 early in-order u1", 32'(t1), 2);
      end else begin
        check("R6 early bound u0", 32'(t0 >= 1 && t0 <= N / 2), 1);
        check("R6 early bound u1", 32'(t1 >= 2 && t1 <= N), 1);
      end
    end
    early = 1'b0;

    // R9 rank pick
    pa = {3'd2, 3'd7, 3'd0, 3'd5};
    run_one(pa, t0, t1);
    exp = ref_sort(pa);
    for (int r = 0; r < N; r++) begin
      rsel = 2'(r);
      #2;
      check("R9 rank u0", 32'(r0), 32'(exp[r*W +: W]));
      check("R9 rank u1", 32'(r1), 32'(exp[r*W +: W]));
    end

    // R7 hold while idle, win_data moving without strobe
    held = s0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); win = NW'(12'hA5C + k * 37);
    end
    @(negedge clk);
    check("R7 done held u0", 32'(d0), 1);
    check("R7 sorted held u0", 32'(s0), 32'(held));
    check("R7 sorted held u1", 32'(s1), 32'(held));

    // R8 strobe while busy is ignored
    pa = {3'd1, 3'd6, 3'd3, 3'd4};
    pb = {3'd7, 3'd7, 3'd0, 3'd0};
    @(negedge clk); win = pa; strobe = 1'b1;
    @(negedge clk); win = pb;             // still strobing: both busy
    @(negedge clk); strobe = 1'b0;
    check("R8 overrun pulse u0", 32'(o0), 1);
    check("R8 overrun pulse u1", 32'(o1), 1);
    @(negedge clk);
    check("R8 overrun one cycle", 32'({o0, o1}), 0);
    repeat (4) @(negedge clk);
    exp = ref_sort(pa);
    check("R8 ignored strobe u0", 32'(s0), 32'(exp));
    check("R8 ignored strobe u1", 32'(s1), 32'(exp));
    check("R8 done after ignored strobe", 32'({d0, d1}), 3);

    finish_run();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule